// File: doc/BRIEF.md
# Packed Fixed-Point to Floating-Point Lane Converter

This block turns every lane of a packed 64-bit or 128-bit operand from a fixed-point number into an IEEE-754 value of the same width. Lanes are 16, 32 or 64 bits wide. Each lane is read as two's complement or as unsigned. Its value is the lane integer scaled by two to the power of minus a fractional-bit count. One 7-bit shift immediate, split into a 4-bit high part and a 3-bit low part, sets both the lane width and the fractional-bit count.

A request arrives as a one-cycle `start_i` pulse. The block latches the operands and converts one lane per clock. When the last lane is done it presents the packed result, its sticky inexact status and a one-cycle `done_o` pulse. A scalar request converts only the lowest lane. The bits above that lane are either zeroed or taken from the old destination value. An encoding that is not allowed is reported on `undef_o` in the same cycle as the start, and nothing is converted.

Top module: `fxp2fp_packed`

## Requirements
- R1: Lane width W comes from `imm_hi_i`. Bit 3 set gives W=64. Pattern 01xx gives W=32. Pattern 001x gives W=16.
- R2: When idle, a start with `imm_hi_i[3:1]`=000 raises `undef_o` combinationally in that cycle. So does a start with pattern 001 while `half_en_i`=0. No `done_o` follows, and `res_o` and `inexact_o` keep their previous values.
- R3: A vector start (`vec_i`=1) with W=64 and `size_i`=0 is undefined in the same way as R2.
- R4: The fractional-bit count is F = 2*W - {imm_hi_i,imm_lo_i}, read as an unsigned 7-bit value. Each result is the lane integer divided by 2^F.
- R5: In vector mode the register is 128 bits when `size_i`=1 and 64 bits when `size_i`=0, giving 128/W or 64/W lanes. Lane i sits at bits [i*W +: W] of both `src_i` and `res_o`. Scalar mode converts one lane at bits [W-1:0].
- R6: With `uns_i`=1 a lane is unsigned. With `uns_i`=0 it is two's complement, and a negative value sets the sign bit (bit W-1) of the result.
- R7: `rmode_i` encodes rounding: 00 nearest with ties to even, 01 toward +infinity, 10 toward -infinity, 11 toward zero.
- R8: In scalar mode with `merge_i`=1, the bits of `res_o` above the lane equal `dst_old_i`. In every other case all bits above the written lanes are zero.
- R9: A zero lane gives +0.0 (all bits zero) in every rounding mode and signedness.
- R10: Half-precision results below the smallest normal come out as correctly scaled subnormals.
- R11: `inexact_o` is set when any lane discarded nonzero bits. It is sticky across the lanes of one request, is cleared by each accepted start, and is updated together with `done_o`.
- R12: For an N-lane request, `done_o` is a one-cycle pulse seen N clock edges after the edge that accepts `start_i`. `res_o` changes only with `done_o`. A start while busy is ignored and raises no `undef_o`.
- R13: During reset `done_o`, `undef_o`, `inexact_o` and `res_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| vec_i | input | 1 | 1 = vector request, 0 = scalar request |
| size_i | input | 1 | Vector register width: 1 = 128 bits, 0 = 64 bits |
| imm_hi_i | input | 4 | High part of the shift immediate |
| imm_lo_i | input | 3 | Low part of the shift immediate |
| uns_i | input | 1 | 1 = unsigned lanes, 0 = two's complement lanes |
| rmode_i | input | 2 | Rounding mode |
| merge_i | input | 1 | Scalar merge enable |
| half_en_i | input | 1 | Half-precision support enable |
| src_i | input | 128 | Packed fixed-point source |
| dst_old_i | input | 128 | Old destination contents |
| done_o | output | 1 | Result valid pulse |
| undef_o | output | 1 | Undefined-encoding flag |
| res_o | output | 128 | Packed floating-point result |
| inexact_o | output | 1 | Sticky inexact status of the last request |

## Verification
The assertions assume that the encoding and mode inputs are known whenever `start_i` is high in the idle state, and that the operands matter only in that cycle, since the block latches them. The stimulus changes inputs only on the falling edge and holds `start_i` for a single cycle. It waits for `done_o` before the next request, with one exception: a deliberate start during a busy run, which checks that such a start is ignored. No assumption is made on `rmode_i` or on operand values, so the directed cases cover every rounding mode, extreme integers of each width and both signedness settings.

// File: rtl/fxp2fp_pkg.sv
package fxp2fp_pkg;
  localparam int REG_W    = 128;
  localparam int LANE_W   = 64;
  localparam int IMM_HI_W = 4;
  localparam int IMM_LO_W = 3;
  localparam int IMM_W    = IMM_HI_W + IMM_LO_W;
  localparam int FB_W     = 7;
  localparam int IDX_W    = 3;
  localparam int CNT_W    = IDX_W + 1;
  localparam int POS_W    = $clog2(LANE_W);
  localparam int EXT_W    = 2 * LANE_W;

  typedef enum logic [1:0] {
    LW16 = 2'd0,
    LW32 = 2'd1,
    LW64 = 2'd2
  } lane_w_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_POS  = 2'd1,
    RM_NEG  = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;

  typedef struct packed {
    lane_w_e          lw;
    logic [FB_W-1:0]  fbits;
    logic [CNT_W-1:0] lanes;
    logic             undef;
  } dec_t;

  function automatic logic [7:0] lw_bits(lane_w_e lw);
    case (lw)
      LW16:    return 8'd16;
      LW32:    return 8'd32;
      default: return 8'd64;
    endcase
  endfunction
endpackage

// File: rtl/fxp2fp_decode.sv
module fxp2fp_decode
  import fxp2fp_pkg::*;
(
  input  logic [IMM_HI_W-1:0] imm_hi_i,
  input  logic [IMM_LO_W-1:0] imm_lo_i,
  input  logic                vec_i,
  input  logic                size_i,
  input  logic                half_en_i,
  output dec_t                dec_o
);
  logic [IMM_W-1:0] imm;
  logic [7:0]       w8;

  always_comb begin
    imm = {imm_hi_i, imm_lo_i};
    if (imm_hi_i[3])      dec_o.lw = LW64;
    else if (imm_hi_i[2]) dec_o.lw = LW32;
    else                  dec_o.lw = LW16;
    w8 = lw_bits(dec_o.lw);
    // twice the lane width minus the immediate
    dec_o.fbits = FB_W'((w8 << 1) - {1'b0, imm});
    if (!vec_i) begin
      dec_o.lanes = CNT_W'(1);
    end else begin
      case (dec_o.lw)
        LW16:    dec_o.lanes = size_i ? CNT_W'(8) : CNT_W'(4);
        LW32:    dec_o.lanes = size_i ? CNT_W'(4) : CNT_W'(2);
        default: dec_o.lanes = size_i ? CNT_W'(2) : CNT_W'(1);
      endcase
    end
    dec_o.undef = (imm_hi_i[3:1] == 3'b000)
                | ((imm_hi_i[3:1] == 3'b001) & ~half_en_i)
                | (vec_i & imm_hi_i[3] & ~size_i);
  end
endmodule

// File: rtl/fxp2fp_lead_one.sv
module fxp2fp_lead_one #(
  parameter int W  = 64,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] pos_o,
  output logic          zero_o
);
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) pos_o = IW'(i);
    end
    zero_o = ~|vec_i;
  end
endmodule

// File: rtl/fxp2fp_lane_cvt.sv
module fxp2fp_lane_cvt
  import fxp2fp_pkg::*;
(
  input  logic [LANE_W-1:0] raw_i,
  input  lane_w_e           lw_i,
  input  logic [FB_W-1:0]   fbits_i,
  input  logic              uns_i,
  input  rmode_e            rmode_i,
  output logic [LANE_W-1:0] res_o,
  output logic              inexact_o
);
  localparam int SIG_W = 54;

  logic [LANE_W-1:0] val, mag;
  logic              sgn;
  logic [POS_W-1:0]  lead_pos;
  logic              is_zero;

  logic [5:0]         mw;
  logic [10:0]        bias;
  logic [5:0]         wm1;
  logic signed [12:0] p_s, fb_s, mw_s, bias_s, e_s, lsb_a, lsb_b, lsb, eb_s;
  logic               norm;
  logic [6:0]         k, km1;
  logic [EXT_W-1:0]   ext, smask;
  logic [SIG_W-1:0]   sig;
  logic               guard, sticky, inc;
  logic [SIG_W:0]     sig_r;
  logic [10:0]        ebase;
  logic [LANE_W-1:0]  packed_v;

  always_comb begin
    case (lw_i)
      LW16: begin
        val  = uns_i ? {48'b0, raw_i[15:0]} : {{48{raw_i[15]}}, raw_i[15:0]};
        mw   = 6'd10;
        bias = 11'd15;
        wm1  = 6'd15;
      end
      LW32: begin
        val  = uns_i ? {32'b0, raw_i[31:0]} : {{32{raw_i[31]}}, raw_i[31:0]};
        mw   = 6'd23;
        bias = 11'd127;
        wm1  = 6'd31;
      end
      default: begin
        val  = raw_i;
        mw   = 6'd52;
        bias = 11'd1023;
        wm1  = 6'd63;
      end
    endcase
    sgn = ~uns_i & val[LANE_W-1];
    mag = sgn ? (~val + 1'b1) : val;
  end

  fxp2fp_lead_one #(.W(LANE_W)) u_lead (
    .vec_i  (mag),
    .pos_o  (lead_pos),
    .zero_o (is_zero)
  );

  always_comb begin
    p_s    = $signed({7'b0, lead_pos});
    fb_s   = $signed({6'b0, fbits_i});
    mw_s   = $signed({7'b0, mw});
    bias_s = $signed({2'b0, bias});
    e_s    = p_s - fb_s + bias_s;
    lsb_a  = p_s - mw_s;
    // lowest kept bit position once the exponent is pinned at its minimum
    lsb_b  = 13'sd1 - bias_s - mw_s + fb_s;
    norm   = (e_s > 13'sd0);
    lsb    = norm ? lsb_a : lsb_b;
    k      = 7'(lsb + 13'sd64);
    km1    = k - 7'd1;
    ext    = {mag, {LANE_W{1'b0}}};
    sig    = SIG_W'(ext >> k);
    guard  = 1'(ext >> km1);
    smask  = (EXT_W'(1) << km1) - EXT_W'(1);
    sticky = |(ext & smask);
    case (rmode_i)
      RM_NEAR: inc = guard & (sticky | sig[0]);
      RM_POS:  inc = ~sgn & (guard | sticky);
      RM_NEG:  inc = sgn & (guard | sticky);
      default: inc = 1'b0;
    endcase
    sig_r    = {1'b0, sig} + (SIG_W+1)'(inc);
    eb_s     = norm ? (e_s - 13'sd1) : 13'sd0;
    ebase    = 11'(eb_s);
    // mantissa carry rolls into the exponent field by addition
    packed_v = ({53'b0, ebase} << mw) + {9'b0, sig_r};
    if (is_zero) begin
      res_o     = '0;
      inexact_o = 1'b0;
    end else begin
      res_o     = packed_v | ({63'b0, sgn} << wm1);
      inexact_o = guard | sticky;
    end
  end
endmodule

// File: rtl/fxp2fp_packed.sv
module fxp2fp_packed
  import fxp2fp_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                vec_i,
  input  logic                size_i,
  input  logic [IMM_HI_W-1:0] imm_hi_i,
  input  logic [IMM_LO_W-1:0] imm_lo_i,
  input  logic                uns_i,
  input  logic [1:0]          rmode_i,
  input  logic                merge_i,
  input  logic                half_en_i,
  input  logic [REG_W-1:0]    src_i,
  input  logic [REG_W-1:0]    dst_old_i,
  output logic                done_o,
  output logic                undef_o,
  output logic [REG_W-1:0]    res_o,
  output logic                inexact_o
);
  dec_t dec;

  logic             busy_q;
  lane_w_e          lw_q;
  logic [FB_W-1:0]  fbits_q;
  logic [CNT_W-1:0] lanes_q;
  logic             uns_q;
  rmode_e           rmode_q;
  logic [REG_W-1:0] src_q, acc_q, res_q;
  logic [IDX_W-1:0] idx_q;
  logic             inx_acc_q, inx_q, done_q;

  logic             start_ok;
  logic [6:0]       sh;
  logic [LANE_W-1:0] lane_raw, lane_mask, cvt_res;
  logic             cvt_inx, last;
  logic [REG_W-1:0] acc_nxt;

  fxp2fp_decode u_dec (
    .imm_hi_i  (imm_hi_i),
    .imm_lo_i  (imm_lo_i),
    .vec_i     (vec_i),
    .size_i    (size_i),
    .half_en_i (half_en_i),
    .dec_o     (dec)
  );

  assign start_ok = start_i & ~busy_q & ~dec.undef;
  assign undef_o  = start_i & ~busy_q & dec.undef;

  always_comb begin
    case (lw_q)
      LW16: begin
        sh        = {idx_q, 4'b0};
        lane_mask = {48'b0, {16{1'b1}}};
      end
      LW32: begin
        sh        = {idx_q[1:0], 5'b0};
        lane_mask = {32'b0, {32{1'b1}}};
      end
      default: begin
        sh        = {idx_q[0], 6'b0};
        lane_mask = {LANE_W{1'b1}};
      end
    endcase
    lane_raw = LANE_W'(src_q >> sh);
    acc_nxt  = (acc_q & ~(REG_W'(lane_mask) << sh))
             | (REG_W'(cvt_res & lane_mask) << sh);
    last     = ({1'b0, idx_q} == (lanes_q - CNT_W'(1)));
  end

  fxp2fp_lane_cvt u_cvt (
    .raw_i     (lane_raw),
    .lw_i      (lw_q),
    .fbits_i   (fbits_q),
    .uns_i     (uns_q),
    .rmode_i   (rmode_q),
    .res_o     (cvt_res),
    .inexact_o (cvt_inx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      lw_q      <= LW16;
      fbits_q   <= '0;
      lanes_q   <= '0;
      uns_q     <= 1'b0;
      rmode_q   <= RM_NEAR;
      src_q     <= '0;
      acc_q     <= '0;
      res_q     <= '0;
      idx_q     <= '0;
      inx_acc_q <= 1'b0;
      inx_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        busy_q    <= 1'b1;
        lw_q      <= dec.lw;
        fbits_q   <= dec.fbits;
        lanes_q   <= dec.lanes;
        uns_q     <= uns_i;
        rmode_q   <= rmode_e'(rmode_i);
        src_q     <= src_i;
        acc_q     <= (~vec_i & merge_i) ? dst_old_i : '0;
        idx_q     <= '0;
        inx_acc_q <= 1'b0;
      end else if (busy_q) begin
        acc_q     <= acc_nxt;
        inx_acc_q <= inx_acc_q | cvt_inx;
        idx_q     <= idx_q + 1'b1;
        if (last) begin
          busy_q <= 1'b0;
          res_q  <= acc_nxt;
          inx_q  <= inx_acc_q | cvt_inx;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o    = done_q;
  assign res_o     = res_q;
  assign inexact_o = inx_q;
endmodule

// File: rtl/fxp2fp_packed_chk.sv
module fxp2fp_packed_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_i,
  input logic [3:0]   imm_hi_i,
  input logic         vec_i,
  input logic         size_i,
  input logic         half_en_i,
  input logic         undef_o,
  input logic         done_o,
  input logic [127:0] res_o,
  input logic         inexact_o
);
  p_undef_reserved_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && imm_hi_i[3:1] == 3'b000) |-> undef_o);

  p_undef_half_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && imm_hi_i[3:1] == 3'b001 && !half_en_i) |-> undef_o);

  p_undef_no_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |=> !done_o);

  p_vec_dbl_narrow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && vec_i && imm_hi_i[3] && !size_i) |-> undef_o);

  p_inexact_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(inexact_o));

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_res_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(res_o));

  p_busy_no_undef_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !undef_o);
endmodule

bind fxp2fp_packed fxp2fp_packed_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_i    (busy_q),
  .imm_hi_i  (imm_hi_i),
  .vec_i     (vec_i),
  .size_i    (size_i),
  .half_en_i (half_en_i),
  .undef_o   (undef_o),
  .done_o    (done_o),
  .res_o     (res_o),
  .inexact_o (inexact_o)
);

// File: tb/fxp2fp_packed_bench.sv
module fxp2fp_packed_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0, vec_i = 1'b0, size_i = 1'b0;
  logic [3:0]   imm_hi_i = '0;
  logic [2:0]   imm_lo_i = '0;
  logic         uns_i = 1'b0, merge_i = 1'b0, half_en_i = 1'b0;
  logic [1:0]   rmode_i = '0;
  logic [127:0] src_i = '0, dst_old_i = '0;
  logic         done_o, undef_o, inexact_o;
  logic [127:0] res_o;

  int           n_chk = 0, n_bad = 0;
  bit           finished = 1'b0;
  logic [127:0] last_res = '0;
  logic         last_inx = 1'b0;

  always #5 clk_i = ~clk_i;

  fxp2fp_packed u_fxp2fp_packed (
    .clk_i, .rst_ni, .start_i, .vec_i, .size_i, .imm_hi_i, .imm_lo_i,
    .uns_i, .rmode_i, .merge_i, .half_en_i, .src_i, .dst_old_i,
    .done_o, .undef_o, .res_o, .inexact_o
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input bit vec, input bit size, input logic [3:0] hi, input logic [2:0] lo,
                       input bit uns, input logic [1:0] rm, input bit mrg, input bit half,
                       input logic [127:0] old, input logic [127:0] src);
    @(negedge clk_i);
    vec_i = vec; size_i = size; imm_hi_i = hi; imm_lo_i = lo; uns_i = uns;
    rmode_i = rm; merge_i = mrg; half_en_i = half; dst_old_i = old; src_i = src;
    start_i = 1'b1;
    @(posedge clk_i);
    #1 start_i = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk_i);
      cyc++;
      @(negedge clk_i);
      if (done_o) break;
    end
  endtask

  task automatic run_op(input bit vec, input bit size, input logic [3:0] hi, input logic [2:0] lo,
                        input bit uns, input logic [1:0] rm, input bit mrg, input bit half,
                        input logic [127:0] old, input logic [127:0] src,
                        input logic [127:0] exp, input bit exp_inx, input int lanes,
                        input string req);
    int cyc;
    issue(vec, size, hi, lo, uns, rm, mrg, half, old, src);
    wait_done(cyc);
    chk(cyc == lanes, "R12 latency", 128'(cyc), 128'(lanes));
    chk(res_o === exp, req, res_o, exp);
    chk(inexact_o === exp_inx, {req, " R11 inexact"}, 128'(inexact_o), 128'(exp_inx));
    last_res = exp;
    last_inx = exp_inx;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R12 done pulse", 128'(done_o), 128'(0));
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk(done_o == 0 && undef_o == 0 && inexact_o == 0 && res_o == '0, "R13 reset",
        {res_o[124:0], done_o, undef_o, inexact_o}, '0);
  endtask

  // imm 0111_111 -> 32-bit lanes, F=1
  task automatic t_scalar_single;
    run_op(0, 0, 4'b0111, 3'b111, 0, 2'b00, 0, 0, {128{1'b1}}, 128'h3,
           128'h3FC00000, 0, 1, "R1 R4 R8 scalar single 3/2");
    run_op(0, 0, 4'b0111, 3'b111, 0, 2'b00, 0, 0, '0, 128'hFFFFFFFD,
           128'hBFC00000, 0, 1, "R6 signed -3/2");
  endtask

  task automatic t_merge;
    run_op(0, 0, 4'b0111, 3'b111, 0, 2'b00, 1, 0, {32{4'hA}}, 128'h3,
           {{24{4'hA}}, 32'h3FC00000}, 0, 1, "R8 scalar merge");
  endtask

  task automatic t_unsigned;
    run_op(0, 0, 4'b0111, 3'b111, 1, 2'b00, 0, 0, '0, 128'hFFFFFFFD,
           128'h4F000000, 1, 1, "R6 R7 unsigned nearest");
    run_op(0, 0, 4'b0111, 3'b111, 1, 2'b11, 0, 0, '0, 128'hFFFFFFFD,
           128'h4EFFFFFF, 1, 1, "R6 R7 unsigned toward zero");
  endtask

  task automatic t_rounding;
    run_op(0, 0, 4'b0111, 3'b111, 0, 2'b00, 0, 0, '0, 128'h80000001,
           128'hCE800000, 1, 1, "R7 nearest negative");
    run_op(0, 0, 4'b0111, 3'b111, 0, 2'b01, 0, 0, '0, 128'h80000001,
           128'hCE7FFFFF, 1, 1, "R7 toward +inf negative");
    run_op(0, 0, 4'b0111, 3'b111, 0, 2'b10, 0, 0, '0, 128'h80000001,
           128'hCE800000, 1, 1, "R7 toward -inf negative");
    run_op(0, 0, 4'b0111, 3'b111, 0, 2'b11, 0, 0, '0, 128'h80000001,
           128'hCE7FFFFF, 1, 1, "R7 toward zero negative");
  endtask

  task automatic t_vec4s;
    run_op(1, 1, 4'b0111, 3'b111, 0, 2'b00, 0, 0, '0,
           {32'hFFFFFFFE, 32'h0, 32'h2, 32'h1},
           {32'hBF800000, 32'h0, 32'h3F800000, 32'h3F000000}, 0, 4, "R5 R9 vector 4x32");
  endtask

  // imm 0100_000 -> F=32; merge ignored in vector mode
  task automatic t_vec2s;
    run_op(1, 0, 4'b0100, 3'b000, 0, 2'b00, 1, 0, {128{1'b1}},
           {{64{1'b1}}, 32'h6, 32'h4},
           {64'h0, 32'h30C00000, 32'h30800000}, 0, 2, "R4 R5 R8 vector 2x32 F=32");
  endtask

  task automatic t_double;
    run_op(1, 1, 4'b1111, 3'b111, 0, 2'b00, 0, 0, '0,
           {64'h8000000000000000, 64'h1},
           {64'hC3D0000000000000, 64'h3FE0000000000000}, 0, 2, "R1 R5 vector 2x64");
    run_op(0, 0, 4'b1111, 3'b111, 0, 2'b00, 0, 0, '0, 128'h7FFFFFFFFFFFFFFF,
           128'h43D0000000000000, 1, 1, "R1 R7 scalar 64 nearest");
    run_op(0, 0, 4'b1111, 3'b111, 0, 2'b11, 0, 0, '0, 128'h7FFFFFFFFFFFFFFF,
           128'h43CFFFFFFFFFFFFF, 1, 1, "R7 scalar 64 toward zero");
  endtask

  task automatic t_half_vec;
    run_op(1, 1, 4'b0011, 3'b111, 0, 2'b00, 0, 1, '0,
           {64'h0, 16'h7FFF, 16'hFFFF, 16'h0002, 16'h0001},
           {64'h0, 16'h7400, 16'hB800, 16'h3C00, 16'h3800}, 1, 8, "R1 R5 R11 vector 8x16");
  endtask

  // imm 0010_000 -> F=16, results below smallest half normal
  task automatic t_half_sub;
    run_op(0, 0, 4'b0010, 3'b000, 0, 2'b00, 0, 1, '0, 128'h1,
           128'h0100, 0, 1, "R10 half subnormal 1");
    run_op(0, 0, 4'b0010, 3'b000, 1, 2'b00, 0, 1, '0, 128'h3,
           128'h0300, 0, 1, "R10 half subnormal 3");
  endtask

  task automatic t_sticky;
    run_op(1, 1, 4'b0111, 3'b111, 1, 2'b00, 0, 0, '0,
           {32'h6, 32'h4, 32'h2, 32'hFFFFFFFD},
           {32'h40400000, 32'h40000000, 32'h3F800000, 32'h4F000000}, 1, 4, "R11 sticky lane 0");
    run_op(1, 1, 4'b0111, 3'b111, 1, 2'b00, 0, 0, '0,
           {32'h6, 32'h4, 32'h2, 32'h2},
           {32'h40400000, 32'h40000000, 32'h3F800000, 32'h3F800000}, 0, 4, "R11 cleared by start");
  endtask

  task automatic t_zero;
    run_op(0, 0, 4'b0111, 3'b111, 0, 2'b10, 1, 0, {128{1'b1}}, 128'h0,
           {{96{1'b1}}, 32'h0}, 0, 1, "R9 zero toward -inf");
  endtask

  task automatic undef_case(input bit vec, input bit size, input logic [3:0] hi, input bit half,
                            input string req);
    @(negedge clk_i);
    vec_i = vec; size_i = size; imm_hi_i = hi; imm_lo_i = 3'b101; half_en_i = half;
    src_i = {4{32'h12345678}}; dst_old_i = '0; merge_i = 1'b0;
    start_i = 1'b1;
    #1 chk(undef_o == 1'b1, req, 128'(undef_o), 128'(1));
    @(posedge clk_i);
    #1 start_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(done_o == 1'b0, {req, " no done"}, 128'(done_o), 128'(0));
    end
    chk(res_o === last_res, {req, " result kept"}, res_o, last_res);
    chk(inexact_o === last_inx, {req, " inexact kept"}, 128'(inexact_o), 128'(last_inx));
  endtask

  task automatic t_undef;
    undef_case(0, 0, 4'b0001, 1, "R2 reserved 000x");
    undef_case(1, 1, 4'b0011, 0, "R2 half disabled");
    undef_case(1, 0, 4'b1110, 1, "R3 vector 64-bit lanes in 64-bit register");
  endtask

  task automatic t_busy;
    int cyc;
    logic [127:0] exp;
    exp = {32'hBF800000, 32'h0, 32'h3F800000, 32'h3F000000};
    issue(1, 1, 4'b0111, 3'b111, 0, 2'b00, 0, 0, '0, {32'hFFFFFFFE, 32'h0, 32'h2, 32'h1});
    @(negedge clk_i);
    imm_hi_i = 4'b0001; src_i = '0; vec_i = 1'b0;
    start_i = 1'b1;
    #1 chk(undef_o == 1'b0, "R12 start ignored while busy", 128'(undef_o), 128'(0));
    @(posedge clk_i);
    #1 start_i = 1'b0;
    wait_done(cyc);
    chk(res_o === exp, "R12 busy run keeps first operands", res_o, exp);
    last_res = exp;
    last_inx = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_scalar_single();
    t_merge();
    t_unsigned();
    t_rounding();
    t_vec4s();
    t_vec2s();
    t_double();
    t_half_vec();
    t_half_sub();
    t_sticky();
    t_zero();
    t_undef();
    t_busy();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule